// File: doc/BRIEF.md
# Three-Way Sorted Stream Merge with Duplicate Removal

This block combines three streams of 8-bit signed values. Each stream arrives in non-decreasing order. The result is a single stream in strictly increasing order that holds every distinct value seen on any input. Internally, two two-way ordered merge stages form a small tree:

- Stream 0 and stream 1 meet in the first stage.
- That result and stream 2 meet in the second stage.
- The second stage's output passes through a filter that drops any value equal to the one it last emitted.

Every data link is valid/ready. A transfer happens only on a rising clock edge where both valid and ready are high. A producer that has raised valid keeps its data unchanged until the transfer happens. When the consumer drops ready, the stall travels back stage by stage to the three input ports. The back-pressure rules are as follows:

- The output port holds its value while it is stalled.
- Each input port lowers ready once its path is full.
- Each input port also keeps ready low while the merge still waits for a head value on a stream that is still open.

Each input also has a level end signal. The producer raises it once it has nothing left to send, and keeps it high until the block is restarted. An input whose end is high and whose valid is low is finished. It no longer takes part in ordering, and values from the other input pass straight through. The output end flag rises only after all three inputs have finished and every stage has drained. It stays high until reset or a one-cycle restart strobe. The restart strobe also clears the stage registers and the filter's memory so that a new set of streams can begin.

Top module: `sorted_merge3_uniq`

## Requirements
- R1: The output carries, in strictly increasing signed order, exactly the distinct values that appeared on the three inputs, for any pattern of output ready.
- R2: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the following cycle.
- R3: With out_ready held low and all three inputs offering data, all three input ready signals are low within ten cycles, and out_data holds the smallest offered value.
- R4: An input that closes without sending any data does not block the others; their values still appear in full on the output.
- R5: out_end stays low while any input end is low, even when no data is pending. It rises within two cycles of the last input closing once the stages are empty. While it is high, out_valid is low.
- R6: The first value after reset or restart is always emitted, including the value 0 and the value -128 (8'h80).
- R7: Ordering is by two's-complement value, so negative values come out before zero and positive values.
- R8: The restart strobe clears out_end and the filter's memory. A new stream whose first value equals the previous run's last value emits that value.
- R9: After reset, with every input open and idle, out_valid and out_end are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | One-cycle strobe: clear all stage state for a new run |
| s0_valid | input | 1 | Stream 0 data present |
| s0_data | input | 8 | Stream 0 value, signed |
| s0_end | input | 1 | Stream 0 closed (level, held until restart) |
| s0_ready | output | 1 | Block accepts stream 0 this cycle |
| s1_valid | input | 1 | Stream 1 data present |
| s1_data | input | 8 | Stream 1 value, signed |
| s1_end | input | 1 | Stream 1 closed |
| s1_ready | output | 1 | Block accepts stream 1 this cycle |
| s2_valid | input | 1 | Stream 2 data present |
| s2_data | input | 8 | Stream 2 value, signed |
| s2_end | input | 1 | Stream 2 closed |
| s2_ready | output | 1 | Block accepts stream 2 this cycle |
| out_valid | output | 1 | Output value present |
| out_data | output | 8 | Output value, signed |
| out_ready | input | 1 | Consumer accepts the output |
| out_end | output | 1 | All inputs closed and drained (sticky until restart) |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A wrong selection in either merge stage, or a stale head, shows up on the very next output transfer as a value out of order or a missing value.
- A filter memory that is not cleared swallows the first value of the following run.
- Broken stall handling changes out_data during a stalled cycle, which shows within one cycle.
- Broken back-pressure leaves an input ready high after the ten-cycle fill.
- Mishandled end logic either hangs the run or raises out_end while an input is still open, and this is seen within two cycles of the last close.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
  localparam int unsigned SM3_DW = 8;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_A    = 2'd1,
    PICK_B    = 2'd2
  } pick_t;
endpackage

// File: rtl/sm3_merge2.sv
module sm3_merge2
  import sm3_pkg::*;
#(
  parameter int unsigned W = SM3_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  input  logic         a_end,
  output logic         a_ready,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  input  logic         b_end,
  output logic         b_ready,
  output logic         o_valid,
  output logic [W-1:0] o_data,
  output logic         o_end,
  input  logic         o_ready
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         a_done, b_done, slot_free;
  pick_t        pick;

  always_comb begin
    a_done    = a_end && !a_valid;
    b_done    = b_end && !b_valid;
    slot_free = !vld_q || o_ready;
    pick      = PICK_NONE;
    if (a_valid && b_valid)
      pick = ($signed(a_data) <= $signed(b_data)) ? PICK_A : PICK_B;
    else if (a_valid && b_done)
      pick = PICK_A;
    else if (b_valid && a_done)
      pick = PICK_B;
  end

  assign a_ready = slot_free && (pick == PICK_A);
  assign b_ready = slot_free && (pick == PICK_B);
  assign o_valid = vld_q;
  assign o_data  = dat_q;
  assign o_end   = a_done && b_done && !vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (restart) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (slot_free) begin
      vld_q <= (pick != PICK_NONE);
      if (pick == PICK_A)      dat_q <= a_data;
      else if (pick == PICK_B) dat_q <= b_data;
    end
  end
endmodule

// File: rtl/sm3_uniq.sv
module sm3_uniq
  import sm3_pkg::*;
#(
  parameter int unsigned W = SM3_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_end,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_end,
  input  logic         out_ready
);
  logic         vld_q, have_q, end_q;
  logic [W-1:0] dat_q, last_q;
  logic         slot_free, fresh;

  assign slot_free = !vld_q || out_ready;
  assign fresh     = !have_q || (in_data != last_q);
  assign in_ready  = slot_free;
  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_end   = end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      have_q <= 1'b0;
      end_q  <= 1'b0;
      dat_q  <= '0;
      last_q <= '0;
    end else if (restart) begin
      vld_q  <= 1'b0;
      have_q <= 1'b0;
      end_q  <= 1'b0;
      dat_q  <= '0;
      last_q <= '0;
    end else begin
      if (slot_free) begin
        vld_q <= in_valid && fresh;
        if (in_valid && fresh) dat_q <= in_data;
        if (in_valid) begin
          have_q <= 1'b1;
          last_q <= in_data;
        end
      end
      if (in_end && !vld_q) end_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sorted_merge3_uniq.sv
module sorted_merge3_uniq
  import sm3_pkg::*;
#(
  parameter int unsigned W = SM3_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         s0_valid,
  input  logic [W-1:0] s0_data,
  input  logic         s0_end,
  output logic         s0_ready,
  input  logic         s1_valid,
  input  logic [W-1:0] s1_data,
  input  logic         s1_end,
  output logic         s1_ready,
  input  logic         s2_valid,
  input  logic [W-1:0] s2_data,
  input  logic         s2_end,
  output logic         s2_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         out_end
);
  logic         t1_valid, t1_ready, t1_end;
  logic [W-1:0] t1_data;
  logic         t2_valid, t2_ready, t2_end;
  logic [W-1:0] t2_data;

  sm3_merge2 #(.W(W)) i_lower (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .a_valid(s0_valid), .a_data(s0_data), .a_end(s0_end), .a_ready(s0_ready),
    .b_valid(s1_valid), .b_data(s1_data), .b_end(s1_end), .b_ready(s1_ready),
    .o_valid(t1_valid), .o_data(t1_data), .o_end(t1_end), .o_ready(t1_ready)
  );

  sm3_merge2 #(.W(W)) i_upper (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .a_valid(t1_valid), .a_data(t1_data), .a_end(t1_end), .a_ready(t1_ready),
    .b_valid(s2_valid), .b_data(s2_data), .b_end(s2_end), .b_ready(s2_ready),
    .o_valid(t2_valid), .o_data(t2_data), .o_end(t2_end), .o_ready(t2_ready)
  );

  sm3_uniq #(.W(W)) i_dedup (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .in_valid(t2_valid), .in_data(t2_data), .in_end(t2_end), .in_ready(t2_ready),
    .out_valid(out_valid), .out_data(out_data), .out_end(out_end),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/sm3_chk.sv
module sm3_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         restart,
  input logic         s0_end,
  input logic         s1_end,
  input logic         s2_end,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_ready,
  input logic         out_end
);
  logic         seen_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (restart) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (out_valid && out_ready) begin
      seen_q <= 1'b1;
      prev_q <= out_data;
    end
  end

  // R1
  strictly_rising_chk: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (out_valid && out_ready && seen_q) |-> ($signed(out_data) > $signed(prev_q)));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  end_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n || restart)
    out_end |-> (s0_end && s1_end && s2_end));

  // R5
  end_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n || restart)
    out_end |-> !out_valid);

  // R8
  end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_end && !restart) |=> out_end);
endmodule

bind sorted_merge3_uniq sm3_chk #(.W(W)) i_sm3_chk (.*);

// File: tb/test_sorted_merge3_uniq.sv
module test_sorted_merge3_uniq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]        n0;
    logic [2:0]        n1;
    logic [2:0]        n2;
    logic [0:5][7:0]   d0;
    logic [0:5][7:0]   d1;
    logic [0:5][7:0]   d2;
    logic [3:0]        ne;
    logic [0:11][7:0]  e;
    logic [7:0]        stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R1: three overlapping streams, free-flowing consumer
    '{3'd5, 3'd5, 3'd5,
      {8'd3, 8'd5, 8'd7, 8'd7, 8'd9, 8'd0},
      {8'd2, 8'd2, 8'd6, 8'd8, 8'd10, 8'd0},
      {8'd4, 8'd7, 8'd7, 8'd10, 8'd11, 8'd0},
      4'd10,
      {8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9, 8'd10, 8'd11, 8'd0, 8'd0},
      8'h00},
    // R1 R2: same data under an irregular stall pattern
    '{3'd5, 3'd5, 3'd5,
      {8'd3, 8'd5, 8'd7, 8'd7, 8'd9, 8'd0},
      {8'd2, 8'd2, 8'd6, 8'd8, 8'd10, 8'd0},
      {8'd4, 8'd7, 8'd7, 8'd10, 8'd11, 8'd0},
      4'd10,
      {8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9, 8'd10, 8'd11, 8'd0, 8'd0},
      8'b1011_0010},
    // R4 R7: stream 0 empty, negative values
    '{3'd0, 3'd3, 3'd2,
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'hFB, 8'hFF, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'hFB, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0},
      4'd4,
      {8'hFB, 8'hFF, 8'd0, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      8'h55},
    // R6 R7: extremes, first value -128
    '{3'd3, 3'd1, 3'd2,
      {8'h80, 8'h80, 8'd127, 8'd0, 8'd0, 8'd0},
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'hFF, 8'd127, 8'd0, 8'd0, 8'd0, 8'd0},
      4'd4,
      {8'h80, 8'hFF, 8'd0, 8'd127, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      8'h0C},
    // R8: starts with the previous run's last value
    '{3'd0, 3'd0, 3'd1,
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd127, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      4'd1,
      {8'd127, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      8'h00},
    // R4 R5: all three streams empty
    '{3'd0, 3'd0, 3'd0,
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      4'd0,
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      8'h00},
    // R6: first value is zero, repeated zeros collapse
    '{3'd1, 3'd0, 3'd2,
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      4'd1,
      {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
      8'h81}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       sv [3];
  logic [7:0] sd [3];
  logic       se [3];
  logic       sr [3];
  logic       out_valid, out_ready, out_end;
  logic [7:0] out_data;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sorted_merge3_uniq i_sorted_merge3_uniq (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .s0_valid(sv[0]), .s0_data(sd[0]), .s0_end(se[0]), .s0_ready(sr[0]),
    .s1_valid(sv[1]), .s1_data(sd[1]), .s1_end(se[1]), .s1_ready(sr[1]),
    .s2_valid(sv[2]), .s2_data(sd[2]), .s2_end(se[2]), .s2_ready(sr[2]),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .out_end(out_end)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_stream(input int sid, input int n, input logic [0:5][7:0] d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sv[sid] = 1'b1;
      sd[sid] = d[i];
      #1;
      while (!sr[sid]) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    sv[sid] = 1'b0;
    se[sid] = 1'b1;
  endtask

  task automatic consume(input vec_t v, input int k);
    int         got = 0;
    logic       stalled = 1'b0;
    logic [7:0] held = '0;
    logic       done = 1'b0;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      out_ready = !v.stall[cyc % 8];
      #1;
      if (stalled)  // R2
        chk("R2 stalled output held", out_valid && out_data == held, int'(out_data), int'(held));
      if (out_end) begin
        done = 1'b1;
      end else if (out_valid && out_ready) begin
        if (got < int'(v.ne))
          chk("R1 output value", out_data == v.e[got],
              int'($signed(out_data)), int'($signed(v.e[got])));
        got++;
      end
      stalled = out_valid && !out_ready;
      held    = out_data;
    end
    chk("R1 output count", got == int'(v.ne), got, int'(v.ne));
    chk("R5 end reached", done, int'(done), 1);
    chk("R5 no data with end", !out_valid, int'(out_valid), 0);
    if (k < 0) $display("unused");
  endtask

  task automatic do_restart();
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      se[s] = 1'b0;
      sv[s] = 1'b0;
    end
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    #1;
    chk("R8 end cleared by restart", !out_end, int'(out_end), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int s = 0; s < 3; s++) begin
      sv[s] = 1'b0;
      se[s] = 1'b0;
      sd[s] = '0;
    end
    out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) begin
      sv[s] = 1'b0;
      sd[s] = '0;
      se[s] = 1'b0;
    end
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R9
    chk("R9 reset valid low", !out_valid, int'(out_valid), 0);
    chk("R9 reset end low", !out_end, int'(out_end), 0);

    for (int k = 0; k < NV; k++) begin
      fork
        drive_stream(0, int'(VECS[k].n0), VECS[k].d0);
        drive_stream(1, int'(VECS[k].n1), VECS[k].d1);
        drive_stream(2, int'(VECS[k].n2), VECS[k].d2);
        consume(VECS[k], k);
      join
      do_restart();
    end

    // R3: back-pressure reaches every input
    do_reset();
    @(negedge clk);
    out_ready = 1'b0;
    sv[0] = 1'b1; sd[0] = 8'd1;
    sv[1] = 1'b1; sd[1] = 8'd2;
    sv[2] = 1'b1; sd[2] = 8'd3;
    repeat (10) @(negedge clk);
    #1;
    chk("R3 s0_ready low", !sr[0], int'(sr[0]), 0);
    chk("R3 s1_ready low", !sr[1], int'(sr[1]), 0);
    chk("R3 s2_ready low", !sr[2], int'(sr[2]), 0);
    chk("R3 held smallest", out_valid && out_data == 8'd1, int'(out_data), 1);

    // R5: end waits for the last open input
    do_reset();
    @(negedge clk);
    out_ready = 1'b1;
    se[0] = 1'b1;
    se[1] = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    chk("R5 end low while s2 open", !out_end, int'(out_end), 0);
    @(negedge clk);
    se[2] = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R5 end after last close", out_end, int'(out_end), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule